// File: doc/BRIEF.md
# Key-Protected Controller Register File

This block is the configuration register bank of a DRAM controller. It is a 4 KiB window of 32-bit words on a plain word-addressed bus: a write strobe, a word address, write data, and combinational read data. Software must present a key to a protection word before most registers take writes. A different key locks the bank until the next reset.

A write is either stored as given, stored after a fixup, or dropped. Writable registers that are protected only take writes while the bank is unlocked. A short list of exempt words takes writes in every lock state. Three registers rewrite part of the data on the way in. The configuration word keeps its hardware-owned fields, including the RAM-size code taken from a parameter. The PHY status word and the ECC test control word always read back as healthy. Each write dropped by the lock produces a one-cycle `write_blocked_o` pulse.

Top module: `mcr_bank`

## Requirements
- R1: Word 0 is the protection word. An accepted write there stores 0x01 (open) for data 0xFC600309, 0x10 (hard lock) for data 0xDEADDEAD, and 0x00 (soft lock) for any other data. It reads back as that stored code.
- R2: Once word 0 reads 0x10, every write to a protected word is ignored until reset. This includes writes to word 0.
- R3: While soft-locked (word 0 reads 0x00), writes to protected words other than word 0 are dropped. Writes to word 0 are still decoded as in R1.
- R4: The words at byte offsets 0x50, 0x6C, 0x74, 0x78, 0x7C, 0x88, 0x8C and 0xB4 (word addresses 0x14, 0x1B, 0x1D, 0x1E, 0x1F, 0x22, 0x23, 0x2D) store their data as written in any lock state.
- R5: The configuration word (word 1) ignores write data in bits 31:28, 19:14, 6, 3:2 and 1:0. It always reads bits 31:28 = 3, bits 3:2 = 3, and bits 19:14 and 6 = 0. The other bits take the write data.
- R6: Bits 1:0 of word 1 hold the index of parameter RAM_MIB in {256, 512, 1024, 2048}. Any other value stops elaboration. With the default of 1024 the field reads 2.
- R7: A write to word 0x18 (byte 0x60) stores bit 0 as 0 and bit 4 as 1. All other bits are stored as written.
- R8: A write to word 0x1C (byte 0x70) stores bit 12 as 1 and bit 13 as 0. All other bits are stored as written.
- R9: After reset, word 0 reads 0x00 and word 1 reads 0x3000000C with the size index in bits 1:0. Word 0x100 reads 0x2, words 0x11A and 0x11F read 0xFF, and word 0x114 reads 0x0FFFFFFF. Every other word reads 0.
- R10: A read at a word address of NUM_WORDS or above returns 0. A write there changes no register and raises no block pulse.
- R11: `write_blocked_o` is high for exactly the one cycle after a clock edge at which a write was dropped by the lock. It is low at all other times.
- R12: While the bank is open, a write to an ordinary protected word is stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes take effect on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W (10) | Word address within the 4 KiB window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| write_blocked_o | output | 1 | One-cycle pulse after a write dropped by the lock |

## Verification
The assertions assume that the address and write data are steady around each rising edge while the strobe is high. They also assume the strobe is high for one edge per intended write, so a single write causes a single edge-time decision. Some checks read a word back in the cycle after a write to it; those checks take it for granted that the address stays on that word for the read. The bench follows these rules. It drives every input at the falling edge and holds the strobe high across exactly one rising edge. It then reads the same word back before the next rising edge.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {LK_SOFT, LK_OPEN, LK_HARD} lock_e;

  localparam logic [31:0] KEY_OPEN  = 32'hFC60_0309;
  localparam logic [31:0] KEY_HARD  = 32'hDEAD_DEAD;
  localparam logic [31:0] CODE_OPEN = 32'h0000_0001;
  localparam logic [31:0] CODE_HARD = 32'h0000_0010;
  localparam logic [31:0] CODE_SOFT = 32'h0000_0000;

  localparam int unsigned W_PROT  = 32'h000;
  localparam int unsigned W_CONF  = 32'h001;
  localparam int unsigned W_PHYST = 32'h018;
  localparam int unsigned W_ECCT  = 32'h01C;
  localparam int unsigned W_PHY   = 32'h100;

  // hardware-owned fields of the configuration word
  localparam logic [31:0] CONF_HW_MASK  = 32'hF00F_C04F;
  localparam logic [31:0] CONF_HW_FIXED = 32'h3000_000C;

  function automatic int ram_index(int mib);
    case (mib)
      256:     return 0;
      512:     return 1;
      1024:    return 2;
      2048:    return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic is_exempt(int unsigned w);
    case (w)
      32'h14, 32'h1B, 32'h1D, 32'h1E,
      32'h1F, 32'h22, 32'h23, 32'h2D: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] reset_word(int unsigned w, logic [1:0] ridx);
    case (w)
      W_CONF:        return CONF_HW_FIXED | {30'd0, ridx};
      W_PHY:         return 32'h0000_0002;
      W_PHY + 32'h1A,
      W_PHY + 32'h1F: return 32'h0000_00FF;
      W_PHY + 32'h14: return 32'h0FFF_FFFF;
      default:       return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/mcr_lock.sv
module mcr_lock
  import mcr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output lock_e             state_o,
  output logic [DATA_W-1:0] code_o
);
  lock_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  st_q <= LK_SOFT;
    else if (upd_i) begin
      if (wdata_i == KEY_OPEN)      st_q <= LK_OPEN;
      else if (wdata_i == KEY_HARD) st_q <= LK_HARD;
      else                          st_q <= LK_SOFT;
    end
  end

  always_comb begin
    case (st_q)
      LK_OPEN: code_o = CODE_OPEN;
      LK_HARD: code_o = CODE_HARD;
      default: code_o = CODE_SOFT;
    endcase
  end

  assign state_o = st_q;
endmodule

// File: rtl/mcr_wfilter.sv
module mcr_wfilter
  import mcr_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_WORDS = 384
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  lock_e             lock_i,
  input  logic [1:0]        ridx_i,
  output logic              in_range_o,
  output logic              prot_upd_o,
  output logic              store_we_o,
  output logic              drop_o,
  output logic [DATA_W-1:0] data_o
);
  int unsigned w;
  logic exempt, is_prot, ok;

  always_comb begin
    w          = 32'(addr_i);
    in_range_o = w < 32'(NUM_WORDS);
    exempt     = is_exempt(w);
    is_prot    = (w == W_PROT);
    drop_o     = wr_en_i && in_range_o && !exempt &&
                 ((lock_i == LK_HARD) || (lock_i == LK_SOFT && !is_prot));
    ok         = wr_en_i && in_range_o && !drop_o;
    prot_upd_o = ok && is_prot;
    store_we_o = ok && !is_prot;

    data_o = wdata_i;
    if (w == W_CONF)
      data_o = (wdata_i & ~CONF_HW_MASK) | CONF_HW_FIXED | {30'd0, ridx_i};
    else if (w == W_PHYST)
      data_o = (wdata_i & ~32'h0000_0001) | 32'h0000_0010;
    else if (w == W_ECCT)
      data_o = (wdata_i & ~32'h0000_2000) | 32'h0000_1000;
  end
endmodule

// File: rtl/mcr_store.sv
module mcr_store
  import mcr_pkg::*;
#(
  parameter int NUM_WORDS = 384,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        ridx_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [NUM_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= reset_word(i, ridx_i);
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/mcr_bank.sv
module mcr_bank
  import mcr_pkg::*;
#(
  parameter int WINDOW_BYTES = 4096,
  parameter int NUM_WORDS    = 384,
  parameter int RAM_MIB      = 1024,
  localparam int ADDR_W      = $clog2(WINDOW_BYTES / 4),
  localparam int IDX_W       = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              write_blocked_o
);
  localparam int RIDX = ram_index(RAM_MIB);

  if (RIDX < 0) begin : g_bad_size
    $error("mcr_bank: RAM_MIB must be 256, 512, 1024 or 2048");
  end
  if (NUM_WORDS <= 32'h11F || IDX_W > ADDR_W) begin : g_bad_depth
    $error("mcr_bank: NUM_WORDS must cover the PHY words and fit the window");
  end

  localparam logic [1:0] RIDX2 = RIDX[1:0];

  lock_e             lock_st;
  logic [DATA_W-1:0] lock_code, fix_data, store_rdata;
  logic              in_range, prot_upd, store_we, drop, blocked_q;

  mcr_wfilter #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) i_wfilter (
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .lock_i    (lock_st),
    .ridx_i    (RIDX2),
    .in_range_o(in_range),
    .prot_upd_o(prot_upd),
    .store_we_o(store_we),
    .drop_o    (drop),
    .data_o    (fix_data)
  );

  mcr_lock i_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (prot_upd),
    .wdata_i(wdata_i),
    .state_o(lock_st),
    .code_o (lock_code)
  );

  mcr_store #(.NUM_WORDS(NUM_WORDS)) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ridx_i (RIDX2),
    .we_i   (store_we),
    .idx_i  (addr_i[IDX_W-1:0]),
    .wdata_i(fix_data),
    .rdata_o(store_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) blocked_q <= 1'b0;
    else         blocked_q <= drop;
  end

  always_comb begin
    if (!in_range)                     rdata_o = '0;
    else if (32'(addr_i) == W_PROT)    rdata_o = lock_code;
    else                               rdata_o = store_rdata;
  end

  assign write_blocked_o = blocked_q;
endmodule

// File: rtl/mcr_bank_chk.sv
module mcr_bank_chk
  import mcr_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int NUM_WORDS    = 384,
  parameter logic [1:0] RIDX = 2'd2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              write_blocked_o,
  input lock_e             lock_st
);
  logic in_rng, exm;
  assign in_rng = 32'(addr_i) < 32'(NUM_WORDS);
  assign exm    = is_exempt(32'(addr_i));

  assert_key_open_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && 32'(addr_i) == W_PROT && lock_st != LK_HARD && wdata_i == KEY_OPEN)
    |=> (lock_st == LK_OPEN && rdata_o == CODE_OPEN));

  assert_hard_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_st == LK_HARD) |=> (lock_st == LK_HARD));

  assert_soft_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && lock_st == LK_SOFT && in_rng && !exm && 32'(addr_i) != W_PROT)
    |=> write_blocked_o);

  assert_exempt_open_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && exm) |=> !write_blocked_o);

  assert_conf_fields_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(addr_i) == W_CONF) |-> ((rdata_o & CONF_HW_MASK) == (CONF_HW_FIXED | {30'd0, RIDX})));

  assert_phy_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && 32'(addr_i) == W_PHYST && lock_st == LK_OPEN)
    |=> (32'(addr_i) != W_PHYST || (rdata_o[4] && !rdata_o[0])));

  assert_ecc_ctrl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && 32'(addr_i) == W_ECCT && lock_st == LK_OPEN)
    |=> (32'(addr_i) != W_ECCT || (rdata_o[12] && !rdata_o[13])));

  assert_oob_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_rng |-> (rdata_o == '0));

  assert_pulse_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_blocked_o |-> $past(wr_en_i));
endmodule

bind mcr_bank mcr_bank_chk #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .RIDX(RIDX2)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .addr_i         (addr_i),
  .wdata_i        (wdata_i),
  .rdata_o        (rdata_o),
  .write_blocked_o(write_blocked_o),
  .lock_st        (lock_st)
);

// File: tb/test_mcr_bank.sv
module test_mcr_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        blocked;
  int          errs = 0;
  int          checks = 0;
  bit          done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mcr_bank i_mcr_bank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .write_blocked_o(blocked)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(10'h000, v);  chk("R9 prot", v, 32'h0);
    rd(10'h001, v);  chk("R9 R6 conf", v, 32'h3000_000E);
    rd(10'h100, v);  chk("R9 phy", v, 32'h2);
    rd(10'h11A, v);  chk("R9 eye0", v, 32'hFF);
    rd(10'h11F, v);  chk("R9 eye1", v, 32'hFF);
    rd(10'h114, v);  chk("R9 win", v, 32'h0FFF_FFFF);
    rd(10'h002, v);  chk("R9 other", v, 32'h0);
    chk("R9 blocked", {31'd0, blocked}, 32'h0);
  endtask

  task automatic t_soft();
    logic [31:0] v;
    logic [9:0] ex [8] = '{10'h14, 10'h1B, 10'h1D, 10'h1E, 10'h1F, 10'h22, 10'h23, 10'h2D};
    wr(10'h002, 32'h1234_5678);
    chk("R3 R11 pulse", {31'd0, blocked}, 32'h1);
    rd(10'h002, v);  chk("R3 dropped", v, 32'h0);
    @(negedge clk);
    chk("R11 one cycle", {31'd0, blocked}, 32'h0);
    foreach (ex[i]) begin
      wr(ex[i], 32'hA5A5_0000 | 32'(i));
      chk("R4 no pulse", {31'd0, blocked}, 32'h0);
      rd(ex[i], v);  chk("R4 exempt", v, 32'hA5A5_0000 | 32'(i));
    end
  endtask

  task automatic t_open();
    logic [31:0] v;
    wr(10'h000, 32'hFC60_0309);
    chk("R1 R3 key no pulse", {31'd0, blocked}, 32'h0);
    rd(10'h000, v);  chk("R1 open", v, 32'h01);
    wr(10'h002, 32'hCAFE_F00D);
    rd(10'h002, v);  chk("R12 stored", v, 32'hCAFE_F00D);
  endtask

  task automatic t_fixups();
    logic [31:0] v;
    wr(10'h001, 32'hFFFF_FFFF);
    rd(10'h001, v);  chk("R5 R6 conf ones", v, 32'h3FF0_3FBE);
    wr(10'h001, 32'h0);
    rd(10'h001, v);  chk("R5 conf zero", v, 32'h3000_000E);
    wr(10'h018, 32'hFFFF_FFFF);
    rd(10'h018, v);  chk("R7 ones", v, 32'hFFFF_FFFE);
    wr(10'h018, 32'h0);
    rd(10'h018, v);  chk("R7 zero", v, 32'h0000_0010);
    wr(10'h01C, 32'hFFFF_FFFF);
    rd(10'h01C, v);  chk("R8 ones", v, 32'hFFFF_DFFF);
    wr(10'h01C, 32'h0);
    rd(10'h01C, v);  chk("R8 zero", v, 32'h0000_1000);
  endtask

  task automatic t_oob();
    logic [31:0] v;
    rd(10'h3FF, v);  chk("R10 read top", v, 32'h0);
    wr(10'h200, 32'hDEAD_DEAD);
    chk("R10 no pulse", {31'd0, blocked}, 32'h0);
    rd(10'h200, v);  chk("R10 read", v, 32'h0);
    rd(10'h000, v);  chk("R10 no alias", v, 32'h01);
  endtask

  task automatic t_relock();
    logic [31:0] v;
    wr(10'h000, 32'h1234_5678);
    rd(10'h000, v);  chk("R1 soft code", v, 32'h0);
    wr(10'h003, 32'h77);
    chk("R3 pulse", {31'd0, blocked}, 32'h1);
    rd(10'h003, v);  chk("R3 dropped", v, 32'h0);
    wr(10'h000, 32'hFC60_0309);
    rd(10'h000, v);  chk("R3 reopen", v, 32'h01);
  endtask

  task automatic t_hard();
    logic [31:0] v;
    wr(10'h000, 32'hDEAD_DEAD);
    rd(10'h000, v);  chk("R1 hard code", v, 32'h10);
    wr(10'h000, 32'hFC60_0309);
    chk("R2 key pulse", {31'd0, blocked}, 32'h1);
    rd(10'h000, v);  chk("R2 sticky", v, 32'h10);
    wr(10'h002, 32'h0);
    rd(10'h002, v);  chk("R2 dropped", v, 32'hCAFE_F00D);
    wr(10'h01D, 32'h5A);
    rd(10'h01D, v);  chk("R4 hard exempt", v, 32'h5A);
    do_reset();
    rd(10'h000, v);  chk("R2 R9 reset clears", v, 32'h0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_soft();
    t_open();
    t_fixups();
    t_oob();
    t_relock();
    t_hard();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule